// File: doc/BRIEF.md
# CPU Memory-Access Security Monitor

This block sits between a soft processor core and its memory bus and inspects every request the core makes. Two kinds of instruction fetch are refused. The first is any fetch from the dedicated firmware RAM. The second is any fetch from an application-chosen region, such as the stack, and this applies only after software has armed the monitor. A refused fetch is still carried out on the bus, but the word returned to the core is replaced by an illegal opcode, so the core enters its trap state. Data loads and stores are never altered.

Any access that falls inside the RAM address window but beyond the end of the physical memory is not forwarded. The monitor then raises a halt that freezes the core until reset. A sticky trap indicator, which drives an external red LED, records either a refused fetch or a trap reported by the core.

The core-side request is a valid/ready stream. The core raises `cpu_req_valid_i` and must hold the address, kind, strobes and write data steady until it sees `cpu_req_ready_o` high at a clock edge. Memory back-pressure (`mem_req_ready_i` low) passes straight through to the core. The response word is returned in the same cycle as the accepting ready. Software configures the monitor through a small register port: an arm control, a region first address and a region last address.

Top module: `secmon_top`

## Requirements
- R1: An instruction fetch (`cpu_req_instr_i`=1) whose address lies in the firmware RAM range [FW_BASE, FW_BASE+FW_SIZE-1] returns 32'h0000_0000 on `cpu_rsp_data_o`. This holds whether the monitor is armed or not.
- R2: While armed, an instruction fetch whose address lies in the inclusive range [region first, region last] returns 32'h0000_0000. A region whose first address is greater than its last address matches nothing. While unarmed, the region has no effect.
- R3: Data accesses (`cpu_req_instr_i`=0) at any address return `mem_rsp_data_i` unchanged. Instruction fetches outside both protected ranges also return `mem_rsp_data_i` unchanged.
- R4: A register write with `cfg_sel_i`=0 and `cfg_wdata_i[0]`=1 arms the monitor from the next cycle onward. No write clears the armed state; only reset does. A read with `cfg_sel_i`=0 returns the armed state in bit 0.
- R5: Writes with `cfg_sel_i`=1 (region first) and `cfg_sel_i`=2 (region last) load the low ADDR_W bits of `cfg_wdata_i` while unarmed. Once armed, such writes are ignored. Reads with the same select values return the stored values, zero-extended.
- R6: A valid request at an address inside [RAM_BASE, RAM_BASE+RAM_SPAN-1] whose offset from RAM_BASE is at least RAM_PHYS is neither forwarded (`mem_req_valid_o`=0) nor accepted (`cpu_req_ready_o`=0). `cpu_halt_o` rises at the next clock edge. An access at offset RAM_PHYS-1 is forwarded normally.
- R7: `cpu_halt_o` stays high until reset. While it is high, no request is forwarded and `cpu_req_ready_o` stays low.
- R8: `trap_ind_o` rises one cycle after either an accepted refused fetch or a cycle with `cpu_trap_i` high. It stays high until reset.
- R9: After reset the monitor is unarmed, both region registers read 0, and `cpu_halt_o` and `trap_ind_o` are low.
- R10: When nothing blocks a request, `mem_req_valid_o` follows `cpu_req_valid_i`, `cpu_req_ready_o` follows `mem_req_ready_i`, and address, strobes and write data pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_valid_i | input | 1 | Core request valid |
| cpu_req_ready_o | output | 1 | Request accepted this cycle |
| cpu_req_instr_i | input | 1 | Request is an instruction fetch |
| cpu_req_addr_i | input | ADDR_W | Request byte address |
| cpu_req_wstrb_i | input | DATA_W/8 | Write byte strobes (0 for a read) |
| cpu_req_wdata_i | input | DATA_W | Write data |
| cpu_rsp_data_o | output | DATA_W | Read word to the core, valid with ready |
| mem_req_valid_o | output | 1 | Forwarded request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | ADDR_W | Forwarded address |
| mem_req_wstrb_o | output | DATA_W/8 | Forwarded strobes |
| mem_req_wdata_o | output | DATA_W | Forwarded write data |
| mem_rsp_data_i | input | DATA_W | Read word from memory, valid with ready |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 arm, 1 region first, 2 region last |
| cfg_wdata_i | input | DATA_W | Register write data |
| cfg_rdata_o | output | DATA_W | Register read data for `cfg_sel_i` |
| cpu_trap_i | input | 1 | Trap state reported by the core |
| cpu_halt_o | output | 1 | Sticky halt to the core |
| trap_ind_o | output | 1 | Sticky trap indicator |

## Verification
A flaw in the range decode shows up in the same cycle as the request. The returned word is zero where memory data was expected, or the reverse, and `mem_req_valid_o` or `cpu_req_ready_o` takes the wrong level. Address sweeps across every range edge therefore expose it immediately. A corrupted armed bit or region register can be seen through the register read port. It also shows on the next fetch into the region, when the fetch is replaced or passed through against expectation. Errors in the sticky halt and trap state appear one edge after their cause and then persist, so a single probe a few cycles later catches a flag that failed to set or that cleared itself.

// File: rtl/secmon_pkg.sv
package secmon_pkg;

  // Register select codes on the configuration port
  typedef enum logic [1:0] {
    SEL_ARM   = 2'd0,
    SEL_FIRST = 2'd1,
    SEL_LAST  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  // Window indices inside the range-compare array
  localparam int WIN_FW   = 0;
  localparam int WIN_SPAN = 1;
  localparam int WIN_PHYS = 2;
  localparam int WIN_APP  = 3;
  localparam int NUM_WIN  = 4;

  // Forced opcode: the all-zero word is not a legal base-ISA instruction
  localparam logic [31:0] ILLEGAL_OP = 32'h0000_0000;

endpackage

// File: rtl/secmon_window.sv
// Inclusive address window; an inverted window (first > last) never hits.
module secmon_window #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  output logic          hit_o
);
  logic ordered;
  logic above;
  logic below;

  always_comb begin
    ordered = (first_i <= last_i);
    above   = (addr_i >= first_i);
    below   = (addr_i <= last_i);
    hit_o   = ordered && above && below;
  end
endmodule

// File: rtl/secmon_sticky.sv
// Set-only flag cleared by reset alone.
module secmon_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/secmon_cfg.sv
// Configuration registers: write-once arm bit, region bounds locked by it.
module secmon_cfg
  import secmon_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          armed_o,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] last_o
);
  cfg_sel_e sel;
  logic     arm_set;
  logic     open_wr;

  always_comb begin
    sel     = cfg_sel_e'(sel_i);
    arm_set = we_i && (sel == SEL_ARM) && wdata_i[0];
    open_wr = we_i && !armed_o;
  end

  secmon_sticky u_arm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (arm_set),
    .q_o   (armed_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_o <= '0;
      last_o  <= '0;
    end else if (open_wr) begin
      if (sel == SEL_FIRST) first_o <= wdata_i[AW-1:0];
      if (sel == SEL_LAST)  last_o  <= wdata_i[AW-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ARM:   rdata_o = DW'(armed_o);
      SEL_FIRST: rdata_o = DW'(first_o);
      SEL_LAST:  rdata_o = DW'(last_o);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/secmon_top.sv
module secmon_top
  import secmon_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] FW_BASE  = 32'hD000_0000,
  parameter logic [ADDR_W-1:0] FW_SIZE  = 32'h0000_0800,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] RAM_SPAN = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] RAM_PHYS = 32'h0002_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_req_valid_i,
  output logic                cpu_req_ready_o,
  input  logic                cpu_req_instr_i,
  input  logic [ADDR_W-1:0]   cpu_req_addr_i,
  input  logic [DATA_W/8-1:0] cpu_req_wstrb_i,
  input  logic [DATA_W-1:0]   cpu_req_wdata_i,
  output logic [DATA_W-1:0]   cpu_rsp_data_o,
  output logic                mem_req_valid_o,
  input  logic                mem_req_ready_i,
  output logic [ADDR_W-1:0]   mem_req_addr_o,
  output logic [DATA_W/8-1:0] mem_req_wstrb_o,
  output logic [DATA_W-1:0]   mem_req_wdata_o,
  input  logic [DATA_W-1:0]   mem_rsp_data_i,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_sel_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  output logic [DATA_W-1:0]   cfg_rdata_o,
  input  logic                cpu_trap_i,
  output logic                cpu_halt_o,
  output logic                trap_ind_o
);
  localparam logic [ADDR_W-1:0] FW_LAST   = FW_BASE + FW_SIZE - 1'b1;
  localparam logic [ADDR_W-1:0] SPAN_LAST = RAM_BASE + RAM_SPAN - 1'b1;
  localparam logic [ADDR_W-1:0] PHYS_LAST = RAM_BASE + RAM_PHYS - 1'b1;
  localparam logic [DATA_W-1:0] FORCED    = DATA_W'(ILLEGAL_OP);

  logic              cfg_armed;
  logic [ADDR_W-1:0] cfg_first;
  logic [ADDR_W-1:0] cfg_last;

  secmon_cfg #(.AW(ADDR_W), .DW(DATA_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o),
    .armed_o(cfg_armed),
    .first_o(cfg_first),
    .last_o (cfg_last)
  );

  // Window bounds: three fixed by parameters, one set by software
  logic [ADDR_W-1:0] win_first [NUM_WIN];
  logic [ADDR_W-1:0] win_last  [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;

  always_comb begin
    win_first[WIN_FW]   = FW_BASE;
    win_last[WIN_FW]    = FW_LAST;
    win_first[WIN_SPAN] = RAM_BASE;
    win_last[WIN_SPAN]  = SPAN_LAST;
    win_first[WIN_PHYS] = RAM_BASE;
    win_last[WIN_PHYS]  = PHYS_LAST;
    win_first[WIN_APP]  = cfg_first;
    win_last[WIN_APP]   = cfg_last;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    secmon_window #(.AW(ADDR_W)) u_win (
      .addr_i (cpu_req_addr_i),
      .first_i(win_first[w]),
      .last_i (win_last[w]),
      .hit_o  (win_hit[w])
    );
  end

  logic out_of_phys;
  logic blocked;
  logic no_exec;
  logic fetch_refused;
  logic refused_taken;
  logic halt_set;
  logic trap_set;

  always_comb begin
    out_of_phys   = win_hit[WIN_SPAN] && !win_hit[WIN_PHYS];
    blocked       = cpu_halt_o || out_of_phys;
    no_exec       = win_hit[WIN_FW] || (cfg_armed && win_hit[WIN_APP]);
    fetch_refused = cpu_req_valid_i && cpu_req_instr_i && no_exec;
    refused_taken = fetch_refused && mem_req_valid_o && mem_req_ready_i;
    halt_set      = cpu_req_valid_i && out_of_phys;
    trap_set      = cpu_trap_i || refused_taken;
  end

  // Request stream: pass through unless blocked
  assign mem_req_valid_o = cpu_req_valid_i && !blocked;
  assign cpu_req_ready_o = mem_req_ready_i && !blocked;
  assign mem_req_addr_o  = cpu_req_addr_i;
  assign mem_req_wstrb_o = cpu_req_wstrb_i;
  assign mem_req_wdata_o = cpu_req_wdata_i;
  assign cpu_rsp_data_o  = fetch_refused ? FORCED : mem_rsp_data_i;

  secmon_sticky u_halt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (halt_set),
    .q_o   (cpu_halt_o)
  );

  secmon_sticky u_trap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (trap_set),
    .q_o   (trap_ind_o)
  );
endmodule

// File: rtl/secmon_chk.sv
module secmon_chk #(
  parameter int              ADDR_W   = 32,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] FW_BASE  = 32'hD000_0000,
  parameter logic [ADDR_W-1:0] FW_SIZE  = 32'h0000_0800,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] RAM_SPAN = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] RAM_PHYS = 32'h0002_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              armed,
  input logic [ADDR_W-1:0] first,
  input logic [ADDR_W-1:0] last,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_instr,
  input logic [ADDR_W-1:0] req_addr,
  input logic              fwd_valid,
  input logic              mem_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              halt,
  input logic              trap
);
  logic [ADDR_W-1:0] off;
  logic              in_fw;
  logic              beyond;

  always_comb begin
    off    = req_addr - RAM_BASE;
    in_fw  = (req_addr >= FW_BASE) && ((req_addr - FW_BASE) < FW_SIZE);
    beyond = (req_addr >= RAM_BASE) && (off < RAM_SPAN) && (off >= RAM_PHYS);
  end

  // R1
  fw_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid && req_instr && in_fw && mem_ready && !halt) |-> (rsp_data == '0));
  // R4
  arm_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> armed);
  // R5
  region_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> ($stable(first) && $stable(last)));
  // R6
  beyond_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid && beyond) |=> halt);
  // R6
  beyond_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid && beyond) |-> (!fwd_valid && !req_ready));
  // R7
  halt_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |=> halt);
  // R7
  halt_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |-> (!fwd_valid && !req_ready));
  // R8
  trap_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap |=> trap);
endmodule

bind secmon_top secmon_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FW_BASE(FW_BASE), .FW_SIZE(FW_SIZE),
  .RAM_BASE(RAM_BASE), .RAM_SPAN(RAM_SPAN), .RAM_PHYS(RAM_PHYS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .armed    (cfg_armed),
  .first    (cfg_first),
  .last     (cfg_last),
  .req_valid(cpu_req_valid_i),
  .req_ready(cpu_req_ready_o),
  .req_instr(cpu_req_instr_i),
  .req_addr (cpu_req_addr_i),
  .fwd_valid(mem_req_valid_o),
  .mem_ready(mem_req_ready_i),
  .rsp_data (cpu_rsp_data_o),
  .halt     (cpu_halt_o),
  .trap     (trap_ind_o)
);

// File: tb/secmon_top_tb_top.sv
`timescale 1ns/1ps
module secmon_top_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int FWB = 'h3000;
  localparam int FWS = 'h0100;
  localparam int RB  = 'h4000;
  localparam int RS  = 'h4000;
  localparam int RP  = 'h1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_instr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_wstrb = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_data;
  logic          mem_valid;
  logic          mem_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_wstrb;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic          trap_in = 1'b0;
  logic          halt;
  logic          trap_ind;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Memory model: word derived from the address, never zero
  assign mem_rdata = {mem_addr, ~mem_addr};

  always #4 clk = ~clk;

  secmon_top #(
    .ADDR_W(AW), .DATA_W(DW),
    .FW_BASE(16'h3000), .FW_SIZE(16'h0100),
    .RAM_BASE(16'h4000), .RAM_SPAN(16'h4000), .RAM_PHYS(16'h1000)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_valid_i(req_valid), .cpu_req_ready_o(req_ready),
    .cpu_req_instr_i(req_instr), .cpu_req_addr_i(req_addr),
    .cpu_req_wstrb_i(req_wstrb), .cpu_req_wdata_i(req_wdata),
    .cpu_rsp_data_o(rsp_data),
    .mem_req_valid_o(mem_valid), .mem_req_ready_i(mem_ready),
    .mem_req_addr_o(mem_addr), .mem_req_wstrb_o(mem_wstrb),
    .mem_req_wdata_o(mem_wdata), .mem_rsp_data_i(mem_rdata),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .cpu_trap_i(trap_in), .cpu_halt_o(halt), .trap_ind_o(trap_ind)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [DW-1:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(logic [1:0] sel, string tag, logic [DW-1:0] exp);
    @(negedge clk);
    cfg_sel = sel;
    #1 chk(tag, cfg_rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0; trap_in = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One combinational probe; valid is dropped before the next edge
  task automatic probe(int a, bit instr, bit armed, int first, int last);
    bit fw, app, beyond, refused;
    logic [AW-1:0] a16;
    a16 = AW'(a);
    fw      = (a >= FWB) && (a < FWB + FWS);
    app     = armed && (first <= last) && (a >= first) && (a <= last);
    beyond  = (a >= RB) && (a < RB + RS) && (a - RB >= RP);
    refused = instr && (fw || app);
    @(negedge clk);
    req_valid = 1'b1; req_instr = instr; req_addr = a16;
    req_wstrb = instr ? 4'h0 : 4'h5; req_wdata = {~a16, a16};
    #1;
    if (beyond) begin
      chk("R6 fwd valid", DW'(mem_valid), 0);
      chk("R6 ready", DW'(req_ready), 0);
    end else begin
      chk("R10 fwd valid", DW'(mem_valid), 1);
      chk("R10 ready", DW'(req_ready), 1);
      chk("R10 addr/strb/wdata", {mem_addr ^ a16, 12'd0, mem_wstrb ^ req_wstrb}, 0);
      chk("R10 wdata", mem_wdata, {~a16, a16});
      if (refused) chk(fw ? "R1 fetch fw" : "R2 fetch app", rsp_data, 0);
      else chk("R3 passthrough", rsp_data, {a16, ~a16});
    end
    #2 req_valid = 1'b0;
  endtask

  task automatic sweep(bit armed, int first, int last);
    int edges[12];
    edges = '{FWB-1, FWB, FWB+FWS-1, FWB+FWS, first-1, first, last, last+1,
              RB+RP-1, RB+RP, RB+RS-1, (RB+RS) & 'hFFFF};
    for (int k = 0; k < 1024; k++) begin
      probe(k * 'h40, 1'b1, armed, first, last);
      probe(k * 'h40 + 4, 1'b0, armed, first, last);
    end
    for (int e = 0; e < 12; e++) begin
      probe(edges[e] & 'hFFFF, 1'b1, armed, first, last);
      probe(edges[e] & 'hFFFF, 1'b0, armed, first, last);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    cfg_read(2'd0, "R9 armed", 0);
    cfg_read(2'd1, "R9 first", 0);
    cfg_read(2'd2, "R9 last", 0);
    chk("R9 halt", DW'(halt), 0);
    chk("R9 trap", DW'(trap_ind), 0);

    sweep(1'b0, 0, 0);
    cfg_write(2'd1, 32'h0000_4100);
    cfg_write(2'd2, 32'hABCD_41FF);
    cfg_read(2'd1, "R5 first load", 32'h4100);
    cfg_read(2'd2, "R5 last load", 32'h41FF);
    sweep(1'b0, 'h4100, 'h41FF);   // R2 unarmed region inert
    cfg_write(2'd0, 32'h1);
    cfg_read(2'd0, "R4 armed", 1);
    sweep(1'b1, 'h4100, 'h41FF);
    cfg_write(2'd1, 32'h0000_0000); // R5 ignored when armed
    cfg_write(2'd2, 32'h0000_FFFF);
    cfg_read(2'd1, "R5 first locked", 32'h4100);
    cfg_read(2'd2, "R5 last locked", 32'h41FF);
    probe('h0040, 1'b1, 1'b1, 'h4100, 'h41FF);  // R5 old region still used
    probe('h4100, 1'b1, 1'b1, 'h4100, 'h41FF);
    cfg_write(2'd0, 32'h0);
    cfg_read(2'd0, "R4 not cleared", 1);
    chk("R8 no trap yet", DW'(trap_ind), 0);

    // Inverted region: first > last matches nothing (R2)
    do_reset();
    cfg_write(2'd1, 32'h5000);
    cfg_write(2'd2, 32'h4F00);
    cfg_write(2'd0, 32'h1);
    sweep(1'b1, 'h5000, 'h4F00);

    // R8 refused fetch accepted at an edge sets the indicator
    @(negedge clk);
    req_valid = 1'b1; req_instr = 1'b1; req_addr = 16'h3010;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 trap after refused fetch", DW'(trap_ind), 1);
    repeat (3) @(negedge clk);
    chk("R8 trap sticky", DW'(trap_ind), 1);

    // R8 core trap input
    do_reset();
    chk("R9 trap cleared", DW'(trap_ind), 0);
    @(negedge clk); trap_in = 1'b1;
    @(negedge clk); trap_in = 1'b0;
    chk("R8 trap from core", DW'(trap_ind), 1);
    @(negedge clk);
    chk("R8 trap held", DW'(trap_ind), 1);

    // R6/R7 access beyond physical RAM
    do_reset();
    @(negedge clk);
    req_valid = 1'b1; req_instr = 1'b0; req_addr = 16'h4FFF;
    #1 chk("R6 last phys not halted", DW'(mem_valid), 1);
    @(negedge clk);
    chk("R6 no halt at last phys", DW'(halt), 0);
    req_addr = 16'h5000;
    #1 chk("R6 beyond blocked", DW'(mem_valid), 0);
    @(negedge clk);
    chk("R6 halt raised", DW'(halt), 1);
    req_addr = 16'h0100;
    #1;
    chk("R7 halted no fwd", DW'(mem_valid), 0);
    chk("R7 halted no ready", DW'(req_ready), 0);
    @(negedge clk); req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 halt sticky", DW'(halt), 1);
    do_reset();
    chk("R9 halt cleared", DW'(halt), 0);

    // R10 memory back-pressure passes through
    @(negedge clk);
    mem_ready = 1'b0; req_valid = 1'b1; req_instr = 1'b0; req_addr = 16'h4004;
    #1;
    chk("R10 stall ready", DW'(req_ready), 0);
    chk("R10 stall valid", DW'(mem_valid), 1);
    @(negedge clk);
    mem_ready = 1'b1; req_valid = 1'b0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule